// File: doc/BRIEF.md
# Path-Addressed Wormhole Packet Switch

This block is the switching core of a small packet router with four byte-wide ports, or three when built that way. Each port carries 9-bit characters: eight data bits and a flag bit that marks an end-of-packet character. Every input and every output uses a valid/ready handshake. The first character of each arriving packet is a physical address that names the output port. The core removes that character, so the next hop sees the following byte as its own address.

When the address is accepted, the input is locked to the named output. Every later character passes straight through the crossbar in the same cycle it is offered. Nothing is stored beyond the single character being offered. The connection is released when the end-of-packet character has been handed to the output. Inputs and outputs that do not overlap carry traffic at the same time. When several inputs ask for the same free output, a round-robin arbiter on that output picks one of them.

Top module: `wormhole_switch`

## Requirements
- R1: After reset no output owns an input, every out_valid is low, and the first valid address to any output is granted in the cycle it is offered.
- R2: A packet whose first character is data byte h, with h below the port count and h different from the arriving port, leaves by output h. The address character itself never appears on any output.
- R3: Once connected, each character offered by the input is presented on its output in the same cycle, unchanged in all 9 bits (flag bit 8 = end-of-packet, bits 7:0 = data). An unblocked packet of n characters, address included, is consumed in exactly n cycles.
- R4: The handshake of the end-of-packet character frees the output. A waiting request for that output is granted in the next cycle.
- R5: Connections between disjoint input/output pairs run at the same time, each at one character per cycle.
- R6: Simultaneous requests for one free output are granted round-robin. The search starts at the port after the last one granted, and the pointer starts at 0 after reset. Inputs that are not granted hold ready low and keep their address character.
- R7: A packet whose address is at or above the port count, or equals its own input port, is accepted and discarded, up to and including its end-of-packet character, and nothing of it appears on any output.
- R8: An end-of-packet character arriving as the first character of a packet is accepted and dropped, and no output is claimed.
- R9: When an output holds ready low, only the input connected to that output stalls, and the stalled character stays presented on the output. Other connections keep streaming.
- R10: While an output is owned, no other input is granted it, so packets on one output never interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | NP*9 | Input characters; port p uses bits p*9+8 : p*9, and bit 8 of each character is the end-of-packet flag |
| in_valid | input | NP | Input character valid, one bit per port |
| in_ready | output | NP | Input character accepted, one bit per port |
| out_data | output | NP*9 | Output characters, laid out in the same way as in_data |
| out_valid | output | NP | Output character valid, one bit per port |
| out_ready | input | NP | Downstream ready, one bit per port |

## Verification
The hardest state to reach is an arbiter pointer that makes round-robin order differ from fixed priority. The bench reaches it after a fresh reset. It first sends two packets to output 3 to move the pointer to port 2, then offers three competing packets at once and expects port 2, then 0, then 1. A second case that needs care is a stalled connection with a second connection running beside it. The bench holds one output not ready while another pair streams, then checks the stall cycle by cycle.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_DROP = 2'd2
  } in_state_t;
endpackage

// File: rtl/sw_in_ctrl.sv
`timescale 1ns/1ps
module sw_in_ctrl
  import sw_pkg::*;
#(
  parameter int NP      = 4,
  parameter int DW      = 8,
  parameter int PORT_ID = 0,
  parameter int SW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW:0]   in_char,
  input  logic          gnt,
  input  logic          sel_rdy,
  output logic          in_ready,
  output logic          want,
  output logic [SW-1:0] want_port,
  output logic          fwd,
  output logic [SW-1:0] sel
);

  localparam logic [DW-1:0] NP_V   = DW'(NP);
  localparam logic [DW-1:0] SELF_V = DW'(PORT_ID);

  in_state_t st, st_nxt;
  logic      is_eop, bad_hdr, load_sel;
  logic [DW-1:0] hdr;

  assign hdr       = in_char[DW-1:0];
  assign is_eop    = in_char[DW];
  assign bad_hdr   = (hdr >= NP_V) || (hdr == SELF_V);
  assign want      = (st == ST_IDLE) && in_valid && !is_eop && !bad_hdr;
  assign want_port = hdr[SW-1:0];
  assign fwd       = (st == ST_FWD);
  assign load_sel  = want && gnt;

  always_comb begin
    st_nxt   = st;
    in_ready = 1'b0;
    case (st)
      ST_IDLE: begin
        in_ready = (is_eop || bad_hdr) ? 1'b1 : gnt;
        if (in_valid && !is_eop && bad_hdr) st_nxt = ST_DROP;
        else if (load_sel)                  st_nxt = ST_FWD;
      end
      ST_FWD: begin
        in_ready = sel_rdy;
        if (in_valid && sel_rdy && is_eop) st_nxt = ST_IDLE;
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && is_eop) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      sel <= '0;
    end else begin
      st <= st_nxt;
      if (load_sel) sel <= want_port;
    end
  end

  assert_eop_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && in_valid && in_ready && is_eop) |=> (st == ST_IDLE));

  assert_loser_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (want && !gnt) |-> !in_ready);

endmodule

// File: rtl/sw_out_arb.sv
`timescale 1ns/1ps
module sw_out_arb #(
  parameter int NP = 4,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          rel,
  output logic [NP-1:0] gnt,
  output logic          busy,
  output logic [SW-1:0] owner
);

  localparam logic [SW-1:0] LAST = SW'(NP - 1);

  logic [SW-1:0] ptr, ptr_nxt, own_nxt, gidx;
  logic          busy_nxt, found, take;

  always_comb begin
    found = 1'b0;
    gidx  = '0;
    for (int k = 0; k < NP; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NP) j = j - NP;
      if (req[j] && !found) begin
        found = 1'b1;
        gidx  = SW'(j);
      end
    end
    take = found && !busy;
    gnt  = take ? ({{(NP-1){1'b0}}, 1'b1} << gidx) : '0;
  end

  always_comb begin
    busy_nxt = busy;
    own_nxt  = owner;
    ptr_nxt  = ptr;
    if (take) begin
      busy_nxt = 1'b1;
      own_nxt  = gidx;
      ptr_nxt  = (gidx == LAST) ? '0 : gidx + 1'b1;
    end else if (rel) begin
      busy_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else begin
      busy  <= busy_nxt;
      owner <= own_nxt;
      ptr   <= ptr_nxt;
    end
  end

  assert_grant_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_owner_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rel) |=> (busy && $stable(owner)));

  assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> !busy);

endmodule

// File: rtl/wormhole_switch.sv
`timescale 1ns/1ps
module wormhole_switch #(
  parameter int NP = 4,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NP*(DW+1)-1:0] in_data,
  input  logic [NP-1:0]      in_valid,
  output logic [NP-1:0]      in_ready,
  output logic [NP*(DW+1)-1:0] out_data,
  output logic [NP-1:0]      out_valid,
  input  logic [NP-1:0]      out_ready
);

  localparam int CW = DW + 1;
  localparam int SW = (NP > 1) ? $clog2(NP) : 1;

  logic [NP-1:0]         want, fwd, gnt_in, sel_rdy, busy, rel;
  logic [NP-1:0][SW-1:0] want_port, sel, owner;
  logic [NP-1:0][NP-1:0] req_m, gnt_m;

  for (genvar i = 0; i < NP; i++) begin : g_in
    sw_in_ctrl #(.NP(NP), .DW(DW), .PORT_ID(i), .SW(SW)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid[i]),
      .in_char   (in_data[i*CW +: CW]),
      .gnt       (gnt_in[i]),
      .sel_rdy   (sel_rdy[i]),
      .in_ready  (in_ready[i]),
      .want      (want[i]),
      .want_port (want_port[i]),
      .fwd       (fwd[i]),
      .sel       (sel[i])
    );
    assign sel_rdy[i] = out_ready[sel[i]];

    assert_fwd_streams_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd[i] && in_valid[i]) |-> out_valid[sel[i]]);
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    sw_out_arb #(.NP(NP), .SW(SW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_m[o]),
      .rel   (rel[o]),
      .gnt   (gnt_m[o]),
      .busy  (busy[o]),
      .owner (owner[o])
    );
  end

  always_comb begin
    gnt_in = '0;
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        req_m[o][i] = want[i] && (want_port[i] == SW'(o));
        if (gnt_m[o][i]) gnt_in[i] = 1'b1;
      end
    end
  end

  always_comb begin
    logic [CW-1:0] oc;
    for (int o = 0; o < NP; o++) begin
      oc = in_data[int'(owner[o])*CW +: CW];
      out_data[o*CW +: CW] = busy[o] ? oc : '0;
      out_valid[o] = busy[o] && in_valid[owner[o]];
      rel[o]       = out_valid[o] && out_ready[o] && oc[DW];
    end
  end

endmodule

// File: tb/sim_wormhole_switch.sv
`timescale 1ns/1ps
module sim_wormhole_switch;
  localparam int NP = 4;
  localparam int CW = 9;
  localparam logic [8:0] EOP = 9'h100;

  logic clk, rst_n;
  logic [NP*CW-1:0] in_data, out_data;
  logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready;

  wormhole_switch #(.NP(NP), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] q  [NP][32];
  int qlen [NP], qpos [NP];
  logic [8:0] lg [NP][32];
  int llen [NP];
  logic [NP-1:0] ordy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) begin qlen[p] = 0; qpos[p] = 0; llen[p] = 0; end
  endtask

  task automatic push(input int p, input logic [8:0] ch);
    q[p][qlen[p]] = ch;
    qlen[p]++;
  endtask

  task automatic cycle();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (qpos[p] < qlen[p]) begin
        in_valid[p] = 1'b1;
        in_data[p*CW +: CW] = q[p][qpos[p]];
      end else begin
        in_valid[p] = 1'b0;
        in_data[p*CW +: CW] = '0;
      end
    end
    out_ready = ordy;
    #1;
    for (int p = 0; p < NP; p++)
      if (in_valid[p] && in_ready[p]) qpos[p]++;
    for (int o = 0; o < NP; o++)
      if (out_valid[o] && out_ready[o] && llen[o] < 32) begin
        lg[o][llen[o]] = out_data[o*CW +: CW];
        llen[o]++;
      end
  endtask

  task automatic drain(input int maxc, output int used);
    bit busyq;
    used = 0;
    busyq = 1'b1;
    while (busyq && used < maxc) begin
      cycle();
      used++;
      busyq = 1'b0;
      for (int p = 0; p < NP; p++) if (qpos[p] < qlen[p]) busyq = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = '0; in_data = '0; out_ready = '1; ordy = '1;
    clear_all();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int used, mism;
    do_reset();

    // R1: idle after reset
    cycle();
    chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);

    // R2 R3 R7: sweep every source and address 0..5
    for (int s = 0; s < NP; s++) begin
      for (int h = 0; h < NP + 2; h++) begin
        bit good;
        logic [7:0] pb [3];
        good = (h < NP) && (h != s);
        clear_all();
        push(s, {1'b0, 8'(h)});
        for (int k = 0; k < 3; k++) begin
          pb[k] = 8'(s*37 + h*11 + k*5 + 1);
          push(s, {1'b0, pb[k]});
        end
        push(s, EOP);
        drain(20, used);
        chk(qpos[s] == 5, "R7 whole packet consumed", qpos[s], 5);
        chk(used == 5, "R3 one character per cycle", used, 5);
        if (good) begin
          mism = 0;
          if (llen[h] != 4) mism++;
          else begin
            for (int k = 0; k < 3; k++) if (lg[h][k] != {1'b0, pb[k]}) mism++;
            if (lg[h][3] != EOP) mism++;
          end
          chk(mism == 0, "R2 routed and address stripped", llen[h], 4);
          for (int o = 0; o < NP; o++)
            if (o != h) chk(llen[o] == 0, "R2 no stray output", llen[o], 0);
        end else begin
          for (int o = 0; o < NP; o++)
            chk(llen[o] == 0, "R7 bad address discarded", llen[o], 0);
        end
      end
    end

    // R8: empty packet claims nothing
    clear_all();
    push(0, EOP);
    push(0, {1'b0, 8'd2}); push(0, {1'b0, 8'hAA}); push(0, EOP);
    push(1, {1'b0, 8'd2}); push(1, {1'b0, 8'hBB}); push(1, EOP);
    drain(30, used);
    chk(llen[2] == 4 && lg[2][0] == 9'h0BB && lg[2][1] == EOP && lg[2][2] == 9'h0AA,
        "R8 empty packet dropped, no claim", lg[2][0], 9'h0BB);

    // R5: four disjoint connections at once
    clear_all();
    for (int s = 0; s < NP; s++) begin
      push(s, {1'b0, 8'(s ^ 1)});
      push(s, {1'b0, 8'(8'h50 + s)});
      push(s, {1'b0, 8'(8'h60 + s)});
      push(s, EOP);
    end
    cycle();
    cycle();
    chk(out_valid == 4'b1111, "R5 all outputs active together", out_valid, 4'hF);
    drain(20, used);
    chk(used == 2, "R5 no slowdown under concurrency", used, 2);
    mism = 0;
    for (int s = 0; s < NP; s++) begin
      int o;
      o = s ^ 1;
      if (llen[o] != 3 || lg[o][0] != {1'b0, 8'(8'h50 + s)} || lg[o][1] != {1'b0, 8'(8'h60 + s)}) mism++;
    end
    chk(mism == 0, "R5 concurrent data intact", mism, 0);

    // R9: backpressure on output 1 only
    clear_all();
    ordy = 4'b1101;
    push(0, {1'b0, 8'd1}); push(0, 9'h011); push(0, 9'h012); push(0, EOP);
    push(2, {1'b0, 8'd3}); push(2, 9'h031); push(2, 9'h032); push(2, EOP);
    cycle();
    mism = 0;
    for (int c = 0; c < 4; c++) begin
      cycle();
      if (in_ready[0] || !out_valid[1] || out_data[1*CW +: CW] != 9'h011) mism++;
    end
    chk(mism == 0, "R9 blocked input stalls with char held", mism, 0);
    chk(llen[3] == 3 && lg[3][2] == EOP, "R9 other connection completes", llen[3], 3);
    chk(llen[1] == 0, "R9 nothing taken from blocked output", llen[1], 0);
    ordy = '1;
    drain(20, used);
    chk(llen[1] == 3 && lg[1][0] == 9'h011 && lg[1][1] == 9'h012, "R9 resumes after release",
        llen[1], 3);

    // R6 R4 R10: round robin after a pointer-moving round
    do_reset();
    for (int s = 0; s < 2; s++) begin
      push(s, {1'b0, 8'd3}); push(s, {1'b0, 8'(8'h40 + s)}); push(s, EOP);
    end
    drain(30, used);
    chk(llen[3] == 4 && lg[3][0] == 9'h040 && lg[3][2] == 9'h041, "R6 first round order",
        lg[3][0], 9'h040);
    clear_all();
    for (int s = 0; s < 3; s++) begin
      push(s, {1'b0, 8'd3}); push(s, {1'b0, 8'(8'h80 + s)}); push(s, EOP);
    end
    cycle();
    chk(in_ready[2:0] == 3'b100, "R6 losers hold ready low", in_ready[2:0], 3'b100);
    drain(30, used);
    chk(used + 1 == 9, "R4 release and regrant without gap", used + 1, 9);
    chk(lg[3][0] == 9'h082 && lg[3][2] == 9'h080 && lg[3][4] == 9'h081,
        "R6 rotating grant order", lg[3][0], 9'h082);
    chk(llen[3] == 6 && lg[3][1] == EOP && lg[3][3] == EOP && lg[3][5] == EOP,
        "R10 packets not interleaved", llen[3], 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule